// File: doc/BRIEF.md
# Conditional-Sum Carry Magnitude Comparator

This block decides whether operand A is greater than or equal to operand B, for two N-bit words where N is a power of two. It never forms a difference. It resolves only the carry out of A plus the bitwise inverse of B plus a carry-in of one. Each bit position first offers two carry candidates: the AND of A and NOT B for an incoming carry of zero, and the OR of A and NOT B for an incoming carry of one. A tree of 2:1 multiplexers then merges neighbouring groups, doubling the resolved group width at each level. After log2(N) levels, a single carry remains, and that carry is the answer.

A parameter chooses between unsigned and two's-complement operands. When the operands are signed and their sign bits differ, the sign bits alone decide the result. A second parameter places a register after every multiplexer level, which gives a latency of log2(N) cycles and accepts one new operand pair per cycle. A valid flag travels alongside the data with the same latency. The block is meant as the compare element of compare-and-swap cells in hardware sorting networks.

Top module: `csc_compare`

## Requirements
- R1: With SIGNED=0, a_ge_b is 1 exactly when A >= B as unsigned integers, and 0 otherwise.
- R2: Equal operands, including all-zero and all-one words, give a_ge_b = 1, because the fixed carry-in of one propagates through every level.
- R3: Operands that differ by one give a_ge_b = 1 when A = B + 1 and a_ge_b = 0 when A = B - 1, whatever the width.
- R4: With SIGNED=1 and differing sign bits (bit N-1), a_ge_b equals the inverse of A's sign bit.
- R5: With SIGNED=1 and equal sign bits, a_ge_b follows two's-complement order. For example, 8'hFF (-1) >= 8'h80 (-128) gives 1.
- R6: With PIPE=0, a_ge_b and out_valid depend on the present inputs with no clock edge between them, and out_valid equals in_valid.
- R7: With PIPE=1, the result and in_valid appear at a_ge_b and out_valid exactly log2(N) rising edges after they are applied.
- R8: A synchronous active-high rst clears every pipeline register, so out_valid is 0 on the cycle after any reset edge while PIPE=1. With PIPE=0, rst has no effect and out_valid follows in_valid.
- R9: With PIPE=1, an operand pair is accepted on every cycle, and results leave in the order the pairs entered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional pipeline registers |
| rst | input | 1 | Synchronous active-high reset of the pipeline |
| in_valid | input | 1 | Marks the operand pair on a and b as meaningful |
| a | input | N | Operand A |
| b | input | N | Operand B |
| out_valid | output | 1 | in_valid delayed by the block latency |
| a_ge_b | output | 1 | 1 when A >= B under the selected interpretation |

## Verification
The hardest case to reach is a carry that has to be carried, not generated or killed, from bit 0 through every multiplexer level. This happens when the operands agree on all upper bits and differ only in the low bits, or do not differ at all. At 8 bits, every operand pair is swept once, so each such chain and each sign combination occurs, with reset pulses and idle slots mixed into the stream. At 64 bits, the stimulus cycles through equal words, neighbours one apart, words differing in a single random bit, and the all-zero and all-one extremes, so that long propagation paths reach the last level.

// File: rtl/csc_pkg.sv
package csc_pkg;

    // Carry out of a bit group, evaluated for both possible incoming carries
    typedef struct packed {
        logic c0;   // group carry out when carry in is 0
        logic c1;   // group carry out when carry in is 1
    } cpair_t;

    // Side information carried alongside the carry tree
    typedef struct packed {
        logic valid;
        logic sdiff;   // signed mode only: sign bits differ
        logic a_neg;   // sign bit of operand A
    } side_t;

    // Conditional-sum merge: the low group's carry selects the high candidate
    function automatic cpair_t merge_pair(input cpair_t hi, input cpair_t lo);
        cpair_t r;
        r.c0 = lo.c0 ? hi.c1 : hi.c0;
        r.c1 = lo.c1 ? hi.c1 : hi.c0;
        return r;
    endfunction

    // Start of level s inside a flat node vector (level 0 holds n leaves)
    function automatic int unsigned lvl_base(input int unsigned n, input int unsigned s);
        return 2 * n - 2 * (n >> s);
    endfunction

endpackage

// File: rtl/csc_leaf.sv
module csc_leaf
    import csc_pkg::*;
#(
    parameter int unsigned N      = 8,
    parameter bit          SIGNED = 1'b0
) (
    input  logic               in_valid,
    input  logic [N-1:0]       a,
    input  logic [N-1:0]       b,
    output cpair_t [N-1:0]     grp,
    output side_t              side
);

    // Per-bit carry candidates of A + ~B. Bit 0 has the fixed carry-in of 1,
    // so its OR term is already the resolved carry.
    for (genvar i = 0; i < N; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            logic lsb_carry;
            assign lsb_carry  = a[i] | ~b[i];
            assign grp[i].c0  = lsb_carry;
            assign grp[i].c1  = lsb_carry;
        end else begin : g_upper
            assign grp[i].c0 = a[i] & ~b[i];
            assign grp[i].c1 = a[i] | ~b[i];
        end
    end

    assign side.valid = in_valid;

    if (SIGNED) begin : g_signed
        assign side.sdiff = a[N-1] ^ b[N-1];
        assign side.a_neg = a[N-1];
    end else begin : g_unsigned
        assign side.sdiff = 1'b0;
        assign side.a_neg = 1'b0;
    end

endmodule

// File: rtl/csc_stage.sv
module csc_stage
    import csc_pkg::*;
#(
    parameter int unsigned GIN = 8,
    parameter bit          REG = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  cpair_t [GIN-1:0]     din,
    input  side_t                sin,
    output cpair_t [GIN/2-1:0]   dout,
    output side_t                sout
);

    localparam int unsigned GOUT = GIN / 2;

    cpair_t [GOUT-1:0] mrg;

    for (genvar k = 0; k < GOUT; k++) begin : g_merge
        assign mrg[k] = merge_pair(din[2*k+1], din[2*k]);
    end

    if (REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                dout <= '0;
                sout <= '0;
            end else begin
                dout <= mrg;
                sout <= sin;
            end
        end
    end else begin : g_comb
        logic unused_clk_rst;
        assign unused_clk_rst = clk ^ rst;
        assign dout = mrg;
        assign sout = sin;
    end

endmodule

// File: rtl/csc_resolve.sv
module csc_resolve
    import csc_pkg::*;
#(
    parameter bit SIGNED = 1'b0
) (
    input  cpair_t root,
    input  side_t  side,
    output logic   ge,
    output logic   valid
);

    // Both halves of the root pair agree, because bit 0 was resolved at the leaf
    logic unused_res;
    assign unused_res = root.c0 ^ side.a_neg ^ side.sdiff;

    if (SIGNED) begin : g_signed
        assign ge = side.sdiff ? ~side.a_neg : root.c1;
    end else begin : g_unsigned
        assign ge = root.c1;
    end

    assign valid = side.valid;

endmodule

// File: rtl/csc_compare.sv
module csc_compare
    import csc_pkg::*;
#(
    parameter int unsigned N      = 8,
    parameter bit          SIGNED = 1'b0,
    parameter bit          PIPE   = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic         out_valid,
    output logic         a_ge_b
);

    localparam int unsigned LVLS  = $clog2(N);
    localparam int unsigned NODES = 2 * N - 1;

    // All tree levels packed into one vector; level s starts at lvl_base(N, s)
    cpair_t [NODES-1:0] node;
    side_t              side_l [0:LVLS];

    csc_leaf #(
        .N      (N),
        .SIGNED (SIGNED)
    ) u_leaf (
        .in_valid (in_valid),
        .a        (a),
        .b        (b),
        .grp      (node[N-1:0]),
        .side     (side_l[0])
    );

    for (genvar s = 0; s < LVLS; s++) begin : g_lvl
        localparam int unsigned GIN  = N >> s;
        localparam int unsigned BIN  = lvl_base(N, s);
        localparam int unsigned BOUT = lvl_base(N, s + 1);

        csc_stage #(
            .GIN (GIN),
            .REG (PIPE)
        ) u_stage (
            .clk  (clk),
            .rst  (rst),
            .din  (node[BIN+GIN-1:BIN]),
            .sin  (side_l[s]),
            .dout (node[BOUT+GIN/2-1:BOUT]),
            .sout (side_l[s+1])
        );
    end

    csc_resolve #(
        .SIGNED (SIGNED)
    ) u_resolve (
        .root  (node[NODES-1]),
        .side  (side_l[LVLS]),
        .ge    (a_ge_b),
        .valid (out_valid)
    );

endmodule

// File: rtl/csc_compare_chk.sv
module csc_compare_chk #(
    parameter int unsigned N      = 8,
    parameter bit          SIGNED = 1'b0,
    parameter bit          PIPE   = 1'b0
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [N-1:0] a,
    input logic [N-1:0] b,
    input logic         out_valid,
    input logic         a_ge_b
);

    localparam int unsigned LAT = PIPE ? $clog2(N) : 0;

    logic ref_ge, ref_sd;
    assign ref_ge = SIGNED ? ($signed(a) >= $signed(b)) : (a >= b);
    assign ref_sd = SIGNED && (a[N-1] != b[N-1]);

    logic exp_v, exp_ge, exp_sd, exp_an;

    if (LAT == 0) begin : g_now
        assign exp_v  = in_valid;
        assign exp_ge = ref_ge;
        assign exp_sd = ref_sd;
        assign exp_an = a[N-1];
    end else begin : g_delay
        logic [LAT-1:0] sh_v, sh_ge, sh_sd, sh_an;
        always_ff @(posedge clk) begin
            if (rst) begin
                sh_v  <= '0;
                sh_ge <= '0;
                sh_sd <= '0;
                sh_an <= '0;
            end else begin
                sh_v[0]  <= in_valid;
                sh_ge[0] <= ref_ge;
                sh_sd[0] <= ref_sd;
                sh_an[0] <= a[N-1];
                for (int i = 1; i < LAT; i++) begin
                    sh_v[i]  <= sh_v[i-1];
                    sh_ge[i] <= sh_ge[i-1];
                    sh_sd[i] <= sh_sd[i-1];
                    sh_an[i] <= sh_an[i-1];
                end
            end
        end
        assign exp_v  = sh_v[LAT-1];
        assign exp_ge = sh_ge[LAT-1];
        assign exp_sd = sh_sd[LAT-1];
        assign exp_an = sh_an[LAT-1];

        AST_RESET_EMPTIES: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !out_valid); // R8
    end

    AST_VALID_TRACK:   assert property (@(posedge clk) disable iff (rst) out_valid == exp_v); // R7
    AST_RESULT_MATCH:  assert property (@(posedge clk) disable iff (rst) exp_v |-> (a_ge_b == exp_ge)); // R1
    AST_SIGN_DECIDES:  assert property (@(posedge clk) disable iff (rst) (exp_v && exp_sd) |-> (a_ge_b == !exp_an)); // R4
    AST_RESULT_KNOWN:  assert property (@(posedge clk) disable iff (rst) out_valid |-> !$isunknown(a_ge_b)); // R5

endmodule

bind csc_compare csc_compare_chk #(
    .N      (N),
    .SIGNED (SIGNED),
    .PIPE   (PIPE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .a         (a),
    .b         (b),
    .out_valid (out_valid),
    .a_ge_b    (a_ge_b)
);

// File: tb/test_csc_compare.sv
module test_csc_compare;

    localparam int PERIOD = 10;
    localparam int L8     = 3;   // log2(8) pipeline stages
    localparam int L64    = 6;   // log2(64) pipeline stages

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vld = 1'b0;
    logic [7:0]  a8 = '0, b8 = '0;
    logic [63:0] a64 = '0, b64 = '0;

    logic ov_u8, ge_u8, ov_s8, ge_s8, ov_64, ge_64;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    // Unsigned, combinational, 8 bits
    csc_compare #(.N(8), .SIGNED(1'b0), .PIPE(1'b0)) i_csc_compare (
        .clk(clk), .rst(rst), .in_valid(vld), .a(a8), .b(b8),
        .out_valid(ov_u8), .a_ge_b(ge_u8));

    // Signed, pipelined, 8 bits
    csc_compare #(.N(8), .SIGNED(1'b1), .PIPE(1'b1)) i_csc_compare_s8 (
        .clk(clk), .rst(rst), .in_valid(vld), .a(a8), .b(b8),
        .out_valid(ov_s8), .a_ge_b(ge_s8));

    // Unsigned, pipelined, 64 bits
    csc_compare #(.N(64), .SIGNED(1'b0), .PIPE(1'b1)) i_csc_compare_u64 (
        .clk(clk), .rst(rst), .in_valid(vld), .a(a64), .b(b64),
        .out_valid(ov_64), .a_ge_b(ge_64));

    // Bench-side delay model of the requirement-level latency (R7, R8)
    bit m8_v [L8];
    bit m8_ge[L8];
    bit m8_sd[L8];
    bit m64_v [L64];
    bit m64_ge[L64];
    int m64_k [L64];
    bit cleared = 1'b0;

    bit cur_rst = 1'b1;
    bit cur_vld = 1'b0;
    bit cur_s8_ge, cur_s8_sd, cur_64_ge;
    int cur_64_k = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string tag64(input int k);
        if (k == 1 || k == 4 || k == 5) return "R2";
        if (k == 2 || k == 3) return "R3";
        return "R1";
    endfunction

    task automatic step(input bit r, input bit v, input logic [7:0] na, input logic [7:0] nb,
                        input logic [63:0] wa, input logic [63:0] wb, input int kind);
        string t8;
        @(posedge clk);
        // advance the latency model by the edge that just happened
        cleared = cur_rst;
        if (cur_rst) begin
            for (int k = 0; k < L8; k++) begin m8_v[k] = 1'b0; m8_ge[k] = 1'b0; m8_sd[k] = 1'b0; end
            for (int k = 0; k < L64; k++) begin m64_v[k] = 1'b0; m64_ge[k] = 1'b0; m64_k[k] = 0; end
        end else begin
            for (int k = L8 - 1; k > 0; k--) begin
                m8_v[k] = m8_v[k-1]; m8_ge[k] = m8_ge[k-1]; m8_sd[k] = m8_sd[k-1];
            end
            m8_v[0] = cur_vld; m8_ge[0] = cur_s8_ge; m8_sd[0] = cur_s8_sd;
            for (int k = L64 - 1; k > 0; k--) begin
                m64_v[k] = m64_v[k-1]; m64_ge[k] = m64_ge[k-1]; m64_k[k] = m64_k[k-1];
            end
            m64_v[0] = cur_vld; m64_ge[0] = cur_64_ge; m64_k[0] = cur_64_k;
        end
        #1;
        rst = r; vld = v; a8 = na; b8 = nb; a64 = wa; b64 = wb;
        cur_rst   = r;
        cur_vld   = v;
        cur_s8_ge = ($signed(na) >= $signed(nb));
        cur_s8_sd = na[7] ^ nb[7];
        cur_64_ge = (wa >= wb);
        cur_64_k  = kind;
        @(negedge clk);
        // combinational unsigned instance: same-cycle result (R6), rst ignored (R8)
        chk(ov_u8 === v, r ? "R8 comb valid" : "R6 comb valid", 64'(ov_u8), 64'(v));
        if (na == nb)                 t8 = "R2";
        else if (na == nb + 8'd1 || nb == na + 8'd1) t8 = "R3";
        else                          t8 = "R1";
        chk(ge_u8 === (na >= nb), {t8, " u8"}, 64'(ge_u8), 64'(na >= nb));
        // pipelined signed instance
        chk(ov_s8 === m8_v[L8-1], cleared ? "R8 s8 valid" : "R7 s8 valid", 64'(ov_s8), 64'(m8_v[L8-1]));
        if (m8_v[L8-1])
            chk(ge_s8 === m8_ge[L8-1], m8_sd[L8-1] ? "R4/R7 s8" : "R5/R7 s8", 64'(ge_s8), 64'(m8_ge[L8-1]));
        // pipelined 64-bit instance, one pair per cycle (R9)
        chk(ov_64 === m64_v[L64-1], cleared ? "R8 u64 valid" : "R7 u64 valid", 64'(ov_64), 64'(m64_v[L64-1]));
        if (m64_v[L64-1])
            chk(ge_64 === m64_ge[L64-1], {tag64(m64_k[L64-1]), "/R9 u64"}, 64'(ge_64), 64'(m64_ge[L64-1]));
    endtask

    task automatic pick64(input int i, output logic [63:0] wa, output logic [63:0] wb, output int kind);
        logic [63:0] r0, r1;
        r0 = {$urandom(), $urandom()};
        r1 = {$urandom(), $urandom()};
        kind = i % 8;
        case (kind)
            0: begin wa = r0; wb = r1; end
            1: begin wa = r0; wb = r0; end
            2: begin wb = r0; wa = r0 + 64'd1; end
            3: begin wb = r0; wa = r0 - 64'd1; end
            4: begin wa = '0; wb = '0; end
            5: begin wa = '1; wb = '1; end
            6: begin wa = r0; wb = r0 ^ (64'd1 << ($urandom() % 64)); end
            default: begin
                if ((i / 8) % 2 == 0) begin wa = '0; wb = '1; end
                else                  begin wa = '1; wb = '0; end
            end
        endcase
    endtask

    initial begin
        fork
            begin
                logic [63:0] wa, wb;
                int kind;
                // reset phase with valid data presented (R8)
                for (int i = 0; i < 4; i++) begin
                    pick64(i, wa, wb, kind);
                    step(1'b1, 1'b1, 8'(i), 8'(3 - i), wa, wb, kind);
                end
                // exhaustive 8-bit sweep, 64-bit structured patterns (R1..R9)
                for (int i = 0; i < 65536; i++) begin
                    bit r;
                    bit v;
                    r = (i == 30000 || i == 30001);
                    v = (i % 37 != 5);
                    pick64(i, wa, wb, kind);
                    step(r, v, i[15:8], i[7:0], wa, wb, kind);
                end
                // drain the pipelines
                for (int i = 0; i < 8; i++)
                    step(1'b0, 1'b0, 8'h00, 8'h00, 64'd0, 64'd0, 4);
                done = 1'b1;
            end
            begin
                repeat (200000) @(posedge clk);
                if (!done) begin
                    checks++;
                    errors++;
                    $display("FAIL watchdog R7 actual=%0h expected=%0h", 0, 1);
                end
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule